// File: doc/BRIEF.md
# End-of-Write Status Polling Read Path

This block sits between the storage array of a paged nonvolatile memory and the data pins. When no internal programming cycle is in progress, a read access returns the array word. While the write controller reports that programming is in progress, the block returns a status word in place of memory contents. The host can then detect completion in either of two ways. It can compare the top data bit with the top bit of the byte it wrote, which reads back inverted until programming ends. It can also watch a second bit that changes value on every separate read access and stops changing when programming ends.

The busy input is the only source of status mode. It is raised for every programming cycle, including a write attempt that protection rejects but that still runs the write timer. The block therefore reads as a status source whenever busy is high, whatever the cause. The last written byte and the array data come from neighbouring logic. All control inputs are synchronous to `clk` and active high.

The mode machine has two states. `MODE_ARRAY` moves to `MODE_POLL` on the transition *enter* (busy sampled high), which also clears the toggle state. `MODE_POLL` moves back to `MODE_ARRAY` on the transition *leave* (busy sampled low). `MODE_POLL` holds on *stay* while busy remains high.

Top module: `eow_status_poll`

## Requirements
- R1: A read access is a cycle with `chip_sel`=1, `out_en`=1 and `wr_en`=0. In any other cycle `dq_oe` is 0 and `dq_out` is all zeros.
- R2: In a read access while the mode is array, `dq_oe` is 1 and `dq_out` equals `array_rdata` in the same cycle.
- R3: The mode becomes poll in the cycle after a rising clock edge that samples `busy`=1. In a poll-mode read, bit 7 of `dq_out` is the inverse of bit 7 of `last_wr_byte`.
- R4: In poll mode, bit 6 of `dq_out` takes a new value on each separate read access. The first access after entering poll mode reads 1, the next reads 0, and so on alternately.
- R5: An access is counted once, at its first cycle. While the enables stay active over several cycles, bit 6 keeps the same value.
- R6: In a poll-mode read, bits 5 down to 0 of `dq_out` equal bits 5 down to 0 of `last_wr_byte`.
- R7: The mode returns to array in the cycle after a rising edge that samples `busy`=0. A read in the cycle in which `busy` falls still returns the status word.
- R8: Each new entry into poll mode restarts the toggle sequence, so the first access of a new write cycle reads bit 6 as 1 again.
- R9: A cycle with `wr_en`=1 is not a read access and does not advance the toggle sequence. This holds even when `chip_sel` and `out_en` are 1.
- R10: After reset the mode is array and the toggle state is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel | input | 1 | Chip select, active high |
| out_en | input | 1 | Output enable, active high |
| wr_en | input | 1 | Write enable, active high |
| busy | input | 1 | Internal programming cycle in progress |
| last_wr_byte | input | 8 | Byte most recently latched for writing |
| array_rdata | input | 8 | Word read from the storage array |
| dq_out | output | 8 | Value for the data pins |
| dq_oe | output | 1 | Enable for the tri-state data driver |

## Verification
The mode register and the toggle register are the internal state of this block. A stuck or late mode register shows on the first read after `busy` changes. The word is then the array word where the status word is due, or the reverse, and the error is visible in that same cycle. A toggle register that misses a clear, double-counts a held access, or counts a write cycle shows as a wrong bit 6 on the next separate read access. The directed scenarios therefore read both at the first possible cycle and on repeated accesses.

// File: rtl/eow_pkg.sv
package eow_pkg;

    typedef enum logic [0:0] {
        MODE_ARRAY = 1'b0,
        MODE_POLL  = 1'b1
    } eow_mode_e;

endpackage

// File: rtl/eow_access_detect.sv
module eow_access_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic chip_sel,
    input  logic out_en,
    input  logic wr_en,
    output logic rd_act,
    output logic rd_start
);

    logic rd_act_q;

    // A read access: selected, outputs enabled, no write strobe.
    assign rd_act   = chip_sel & out_en & ~wr_en;
    // First cycle of an access.
    assign rd_start = rd_act & ~rd_act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_act_q <= 1'b0;
        end else begin
            rd_act_q <= rd_act;
        end
    end

endmodule

// File: rtl/eow_mode_fsm.sv
module eow_mode_fsm
    import eow_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      busy,
    output eow_mode_e mode,
    output logic      poll_entry
);

    eow_mode_e state_q;
    eow_mode_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_ARRAY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        poll_entry = 1'b0;
        unique case (state_q)
            MODE_ARRAY: begin
                if (busy) begin
                    state_d    = MODE_POLL;
                    poll_entry = 1'b1;
                end
            end
            MODE_POLL: begin
                if (!busy) begin
                    state_d = MODE_ARRAY;
                end
            end
            default: state_d = MODE_ARRAY;
        endcase
    end

    assign mode = state_q;

endmodule

// File: rtl/eow_toggle.sv
module eow_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic poll_entry,
    input  logic in_poll,
    input  logic rd_start,
    output logic tgl_shown
);

    logic tgl_q;
    logic count_now;

    assign count_now = in_poll & rd_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgl_q <= 1'b0;
        end else if (poll_entry) begin
            tgl_q <= 1'b0;
        end else if (count_now) begin
            tgl_q <= ~tgl_q;
        end
    end

    // The access shows its post-flip value from its very first cycle.
    assign tgl_shown = tgl_q ^ count_now;

endmodule

// File: rtl/eow_rdmux.sv
module eow_rdmux
    import eow_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int POLL_BIT   = 7,
    parameter int TOGGLE_BIT = 6
) (
    input  eow_mode_e           mode,
    input  logic                rd_act,
    input  logic                tgl_shown,
    input  logic [DATA_W-1:0]   last_byte,
    input  logic [DATA_W-1:0]   array_rdata,
    output logic [DATA_W-1:0]   dq_out,
    output logic                dq_oe
);

    logic [DATA_W-1:0] status_word;

    for (genvar i = 0; i < DATA_W; i++) begin : g_status
        if (i == POLL_BIT) begin : g_inv
            assign status_word[i] = ~last_byte[i];
        end else if (i == TOGGLE_BIT) begin : g_tgl
            assign status_word[i] = tgl_shown;
        end else begin : g_pass
            assign status_word[i] = last_byte[i];
        end
    end

    always_comb begin
        dq_oe  = rd_act;
        dq_out = '0;
        if (rd_act) begin
            unique case (mode)
                MODE_ARRAY: dq_out = array_rdata;
                MODE_POLL:  dq_out = status_word;
                default:    dq_out = array_rdata;
            endcase
        end
    end

endmodule

// File: rtl/eow_status_poll.sv
module eow_status_poll
    import eow_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int POLL_BIT   = DATA_W - 1,
    parameter int TOGGLE_BIT = DATA_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel,
    input  logic              out_en,
    input  logic              wr_en,
    input  logic              busy,
    input  logic [DATA_W-1:0] last_wr_byte,
    input  logic [DATA_W-1:0] array_rdata,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    logic      rd_act;
    logic      rd_start;
    logic      poll_entry;
    logic      tgl_shown;
    eow_mode_e mode;

    eow_access_detect u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .chip_sel (chip_sel),
        .out_en   (out_en),
        .wr_en    (wr_en),
        .rd_act   (rd_act),
        .rd_start (rd_start)
    );

    eow_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .mode       (mode),
        .poll_entry (poll_entry)
    );

    eow_toggle u_tgl (
        .clk        (clk),
        .rst_n      (rst_n),
        .poll_entry (poll_entry),
        .in_poll    (mode == MODE_POLL),
        .rd_start   (rd_start),
        .tgl_shown  (tgl_shown)
    );

    eow_rdmux #(
        .DATA_W     (DATA_W),
        .POLL_BIT   (POLL_BIT),
        .TOGGLE_BIT (TOGGLE_BIT)
    ) u_mux (
        .mode        (mode),
        .rd_act      (rd_act),
        .tgl_shown   (tgl_shown),
        .last_byte   (last_wr_byte),
        .array_rdata (array_rdata),
        .dq_out      (dq_out),
        .dq_oe       (dq_oe)
    );

endmodule

// File: rtl/eow_status_poll_chk.sv
module eow_status_poll_chk #(
    parameter int DATA_W     = 8,
    parameter int POLL_BIT   = DATA_W - 1,
    parameter int TOGGLE_BIT = DATA_W - 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chip_sel,
    input logic              out_en,
    input logic              wr_en,
    input logic              busy,
    input logic [DATA_W-1:0] last_wr_byte,
    input logic [DATA_W-1:0] array_rdata,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe
);

    logic rd;
    assign rd = chip_sel & out_en & ~wr_en;

    // R1: no access, no drive
    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> (!dq_oe && dq_out == '0));

    // R2 / R7: array mode follows the busy level one edge late
    a_r7_array_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !$past(busy)) |-> (dq_oe && dq_out == array_rdata));

    // R3
    a_r3_inverted_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && $past(busy)) |-> (dq_out[POLL_BIT] == ~last_wr_byte[POLL_BIT]));

    // R5: a held access keeps its toggle value
    a_r5_held_access_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && $past(rd) && $past(busy) && $past(busy, 2))
        |-> (dq_out[TOGGLE_BIT] == $past(dq_out[TOGGLE_BIT])));

    // R4 / R8: first access after entry reads one
    a_r8_first_access_one: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !$past(rd) && $past(busy) && !$past(busy, 2)) |-> dq_out[TOGGLE_BIT]);

endmodule

bind eow_status_poll eow_status_poll_chk #(
    .DATA_W     (DATA_W),
    .POLL_BIT   (POLL_BIT),
    .TOGGLE_BIT (TOGGLE_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .chip_sel     (chip_sel),
    .out_en       (out_en),
    .wr_en        (wr_en),
    .busy         (busy),
    .last_wr_byte (last_wr_byte),
    .array_rdata  (array_rdata),
    .dq_out       (dq_out),
    .dq_oe        (dq_oe)
);

// File: tb/eow_status_poll_tb.sv
module eow_status_poll_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chip_sel = 1'b0;
    logic       out_en = 1'b0;
    logic       wr_en = 1'b0;
    logic       busy = 1'b0;
    logic [7:0] last_wr_byte = 8'h00;
    logic [7:0] array_rdata = 8'h00;
    logic [7:0] dq_out;
    logic       dq_oe;

    int checks = 0;
    int fails  = 0;
    bit exp_t  = 1'b0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    eow_status_poll u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .chip_sel     (chip_sel),
        .out_en       (out_en),
        .wr_en        (wr_en),
        .busy         (busy),
        .last_wr_byte (last_wr_byte),
        .array_rdata  (array_rdata),
        .dq_out       (dq_out),
        .dq_oe        (dq_oe)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual oe/dq=%h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] status_of(input logic [7:0] lb, input bit t);
        return {~lb[7], t, lb[5:0]};
    endfunction

    task automatic idle_bus();
        @(negedge clk);
        chip_sel = 1'b0; out_en = 1'b0; wr_en = 1'b0;
    endtask

    // One read access of len cycles; in poll mode the bench toggle advances once.
    task automatic read_access(input int len, input bit poll, input string req);
        if (poll) exp_t = ~exp_t;
        for (int c = 0; c < len; c++) begin
            @(negedge clk);
            chip_sel = 1'b1; out_en = 1'b1; wr_en = 1'b0;
            #2;
            check(req, {dq_oe, dq_out},
                  {1'b1, poll ? status_of(last_wr_byte, exp_t) : array_rdata});
        end
        idle_bus();
        #2;
        check("R1", {dq_oe, dq_out}, 9'h000);
    endtask

    task automatic t_reset();
        #2;
        check("R1", {dq_oe, dq_out}, 9'h000);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        array_rdata = 8'h3C;
        last_wr_byte = 8'hA5;
        read_access(1, 1'b0, "R10");
    endtask

    task automatic t_idle_quiet();
        @(negedge clk);
        chip_sel = 1'b1; out_en = 1'b0; wr_en = 1'b0; #2;
        check("R1", {dq_oe, dq_out}, 9'h000);
        @(negedge clk);
        chip_sel = 1'b0; out_en = 1'b1; #2;
        check("R1", {dq_oe, dq_out}, 9'h000);
        @(negedge clk);
        chip_sel = 1'b1; out_en = 1'b1; wr_en = 1'b1; #2;
        check("R1", {dq_oe, dq_out}, 9'h000);
        idle_bus();
    endtask

    task automatic t_array_read();
        array_rdata = 8'hC3;
        read_access(1, 1'b0, "R2");
        array_rdata = 8'h7E;
        read_access(3, 1'b0, "R2");
    endtask

    task automatic t_poll_sequence();
        last_wr_byte = 8'hA5;
        array_rdata  = 8'h11;
        @(negedge clk) busy = 1'b1;
        exp_t = 1'b0;
        read_access(1, 1'b1, "R3 R4 R6");
        read_access(1, 1'b1, "R4");
        read_access(1, 1'b1, "R4");
    endtask

    task automatic t_hold_access();
        read_access(4, 1'b1, "R5");
        read_access(1, 1'b1, "R5");
    endtask

    task automatic t_write_not_counted();
        @(negedge clk);
        chip_sel = 1'b1; out_en = 1'b1; wr_en = 1'b1; #2;
        check("R9", {dq_oe, dq_out}, 9'h000);
        idle_bus();
        read_access(1, 1'b1, "R9");
    endtask

    task automatic t_exit();
        @(negedge clk);
        busy = 1'b0;
        chip_sel = 1'b1; out_en = 1'b1; wr_en = 1'b0;
        exp_t = ~exp_t;
        #2;
        check("R7", {dq_oe, dq_out}, {1'b1, status_of(last_wr_byte, exp_t)});
        @(negedge clk); #2;
        check("R7", {dq_oe, dq_out}, {1'b1, array_rdata});
        idle_bus();
        read_access(1, 1'b0, "R7");
    endtask

    task automatic t_rearm();
        last_wr_byte = 8'h5A;
        @(negedge clk) busy = 1'b1;
        exp_t = 1'b0;
        read_access(1, 1'b1, "R8");
        read_access(1, 1'b1, "R8");
        @(negedge clk) busy = 1'b0;
        @(negedge clk) busy = 1'b1;
        exp_t = 1'b0;
        read_access(1, 1'b1, "R8");
        @(negedge clk) busy = 1'b0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        t_reset();
        t_idle_quiet();
        t_array_read();
        t_poll_sequence();
        t_hold_access();
        t_write_not_counted();
        t_exit();
        t_rearm();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
        end
    end

endmodule